// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block places a direct-mapped cache between a processor-side word port and a main-memory port that moves data in bursts. Each byte address is split into a line offset, a row index and a tag. Every row holds one line of data. A tag, a valid flag and a dirty flag go with each line. A read that hits returns the selected word of the line. A read that misses holds the processor in a stall. The whole line is then fetched by a burst. The burst's fixed setup delay is a parameter, and after the setup one word arrives per cycle.

Writes follow a write-back policy. A write that hits updates only the cache and marks the line dirty. A write that misses first allocates the line. When a miss lands on a dirty row, the old line is burst out to memory before the new line is fetched. Sizes are parameters. By default a line is 64 bytes (16 words of 32 bits) and there are 64 rows. With the row field widened to 12 bits, the geometry becomes a 256 KB cache.

Top module: `dm_cache`

## Requirements
- R1: Address bits [5:0] are the line offset, the next IDX_W bits (default 6, bits [11:6]) select the row, and the remaining upper bits form the tag. Bits [5:2] select the word within the line and bits [1:0] are ignored. With IDX_W = 12, address 0xA7D304BE splits into tag 0x29F4, row 0xC12 and offset 0x3E.
- R2: Reset clears every valid flag, so the first access to any row after reset is a miss.
- R3: A read hit raises cpu_ready two clock edges after the edge that samples cpu_req. No memory command is issued.
- R4: A miss on a clean or empty row issues exactly one read burst command (mem_cmd high for one cycle, mem_we low, mem_addr line-aligned). cpu_ready rises SETUP_CYCLES + 20 edges after the sampling edge.
- R5: A read burst delivers word k of the line on mem_rdata during the cycle SETUP_CYCLES + k cycles after the cycle in which mem_cmd is high. Words arrive in ascending offset order starting at word 0.
- R6: The processor receives the requested word only after the whole line has been written into the cache. The word is then read from the line, not taken from the memory port.
- R7: A write hit stores the word in the cache and marks the line dirty. It issues no memory command and completes with hit latency.
- R8: A miss on a valid dirty row first issues a write burst (mem_we high) at the victim's line address. mem_wvalid is high with victim word k during the cycle SETUP_CYCLES + k after that command. Only then is the refill command issued. cpu_ready rises 2*SETUP_CYCLES + 36 edges after the sampling edge.
- R9: Two addresses with the same row and different tags evict each other, so alternating accesses to them all miss.
- R10: A write miss refills the line and then applies the write, leaving the line dirty, so the written word reaches memory on the line's later eviction.
- R11: cpu_ready stays low from the sampling edge until the response cycle. It is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request present; held with its fields until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read word, valid with cpu_ready |
| mem_cmd | output | 1 | One-cycle burst start |
| mem_we | output | 1 | Burst direction, 1 = write to memory |
| mem_addr | output | 32 | Line-aligned burst byte address |
| mem_wvalid | output | 1 | Write-burst data beat |
| mem_wdata | output | 32 | Write-burst data word |
| mem_rdata | input | 32 | Read-burst data word, taken on the fixed beat cycles |

## Verification
The bench targets conflict pairs that share a row. If the tag compare or row decode were wrong, these would show as false hits with stale data or as missing write-back bursts. A dirty line is evicted and then read back from memory. A controller that skipped the write-back, or sent beats out of order, would return the original memory pattern instead of the written word. An access to the last word of a line catches beat-index and offset-decode slips. A read after a mid-run reset catches valid flags that survive reset. Exact latency counts for the hit, clean-miss and dirty-miss cases expose a wrong setup count or a refill that forwards early.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMP,
    ST_WB_WAIT,
    ST_WB_DATA,
    ST_RF_WAIT,
    ST_RF_DATA,
    ST_ISSUE,
    ST_DONE
  } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 6,
  parameter int IDX_W  = 6,
  parameter int SEL_W  = 2
) (
  input  logic [ADDR_W-1:0]             addr,
  output logic [ADDR_W-OFS_W-IDX_W-1:0] tag,
  output logic [IDX_W-1:0]              idx,
  output logic [OFS_W-SEL_W-1:0]        word,
  output logic [SEL_W-1:0]              bsel
);
  assign tag  = addr[ADDR_W-1:OFS_W+IDX_W];
  assign idx  = addr[OFS_W+IDX_W-1:OFS_W];
  assign word = addr[OFS_W-1:SEL_W];
  assign bsel = addr[SEL_W-1:0];
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             mark_we,
  input  logic [IDX_W-1:0] mark_idx
);
  localparam int ROWS = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [ROWS];
  logic [ROWS-1:0]  valid_bits;
  logic [ROWS-1:0]  dirty_bits;

  // tag array: plain synchronous RAM, no reset, registered read
  always_ff @(posedge clk) begin
    if (fill_we) tag_mem[fill_idx] <= fill_tag;
    rd_tag <= tag_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_bits <= '0;
      dirty_bits <= '0;
      rd_valid   <= 1'b0;
      rd_dirty   <= 1'b0;
    end else begin
      if (fill_we) begin
        valid_bits[fill_idx] <= 1'b1;
        dirty_bits[fill_idx] <= 1'b0;
      end else if (mark_we) begin
        dirty_bits[mark_idx] <= 1'b1;
      end
      rd_valid <= valid_bits[rd_idx];
      rd_dirty <= dirty_bits[rd_idx];
    end
  end

  assert_no_dual_update_R7: assert property (@(posedge clk) disable iff (rst)
    !(fill_we && mark_we));
endmodule

// File: rtl/dmc_line_ram.sv
module dmc_line_ram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
    rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/dm_cache.sv
module dm_cache #(
  parameter int ADDR_W       = 32,
  parameter int WORD_W       = 32,
  parameter int OFS_W        = 6,
  parameter int IDX_W        = 6,
  parameter int SETUP_CYCLES = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_cmd,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wvalid,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  import dmc_pkg::*;

  localparam int SEL_W  = $clog2(WORD_W / 8);
  localparam int WOFS_W = OFS_W - SEL_W;
  localparam int BEATS  = 1 << WOFS_W;
  localparam int TAG_W  = ADDR_W - OFS_W - IDX_W;
  localparam int RAM_AW = IDX_W + WOFS_W;
  localparam int CNT_W  = $clog2(SETUP_CYCLES + BEATS + 1);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYCLES - 1);
  localparam logic [CNT_W-1:0] BEAT_LAST  = CNT_W'(BEATS - 1);

  dmc_state_e state;

  logic [TAG_W-1:0]  in_tag;
  logic [IDX_W-1:0]  in_idx;
  logic [WOFS_W-1:0] in_word;
  logic [SEL_W-1:0]  unused_bsel;

  logic              req_we;
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WOFS_W-1:0] req_word;
  logic [WORD_W-1:0] req_wdata;
  logic [CNT_W-1:0]  cnt;
  logic [WOFS_W-1:0] beat;

  logic [TAG_W-1:0]  line_tag;
  logic              line_valid;
  logic              line_dirty;
  logic              hit;

  logic [IDX_W-1:0]  look_idx;
  logic [RAM_AW-1:0] ram_raddr;
  logic [RAM_AW-1:0] ram_waddr;
  logic [WORD_W-1:0] ram_wdata;
  logic [WORD_W-1:0] ram_q;
  logic              ram_we;
  logic              fill_we;
  logic              mark_we;

  dmc_addr_split #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .SEL_W(SEL_W)
  ) split_i (
    .addr(cpu_addr), .tag(in_tag), .idx(in_idx), .word(in_word), .bsel(unused_bsel)
  );

  assign beat     = cnt[WOFS_W-1:0];
  assign hit      = line_valid && (line_tag == req_tag);
  assign look_idx = (state == ST_IDLE) ? in_idx : req_idx;

  always_comb begin
    case (state)
      ST_IDLE:    ram_raddr = {in_idx, in_word};
      ST_WB_WAIT: ram_raddr = {req_idx, {WOFS_W{1'b0}}};
      ST_WB_DATA: ram_raddr = {req_idx, beat + WOFS_W'(1)};
      default:    ram_raddr = {req_idx, req_word};
    endcase
  end

  assign mark_we   = (state == ST_CMP) && hit && req_we;
  assign fill_we   = (state == ST_RF_DATA) && (cnt == BEAT_LAST);
  assign ram_we    = mark_we || (state == ST_RF_DATA);
  assign ram_waddr = (state == ST_RF_DATA) ? {req_idx, beat} : {req_idx, req_word};
  assign ram_wdata = (state == ST_RF_DATA) ? mem_rdata : req_wdata;

  assign mem_wvalid = (state == ST_WB_DATA);
  assign mem_wdata  = ram_q;

  dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst(rst),
    .rd_idx(look_idx), .rd_tag(line_tag), .rd_valid(line_valid), .rd_dirty(line_dirty),
    .fill_we(fill_we), .fill_idx(req_idx), .fill_tag(req_tag),
    .mark_we(mark_we), .mark_idx(req_idx)
  );

  dmc_line_ram #(.AW(RAM_AW), .DW(WORD_W)) data_i (
    .clk(clk), .wr_en(ram_we), .wr_addr(ram_waddr), .wr_data(ram_wdata),
    .rd_addr(ram_raddr), .rd_data(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      mem_cmd   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      req_we    <= 1'b0;
      req_tag   <= '0;
      req_idx   <= '0;
      req_word  <= '0;
      req_wdata <= '0;
    end else begin
      mem_cmd <= 1'b0;
      case (state)
        ST_IDLE: if (cpu_req) begin
          req_we    <= cpu_we;
          req_tag   <= in_tag;
          req_idx   <= in_idx;
          req_word  <= in_word;
          req_wdata <= cpu_wdata;
          state     <= ST_CMP;
        end
        ST_CMP: begin
          cnt <= '0;
          if (hit) begin
            cpu_ready <= 1'b1;
            if (!req_we) cpu_rdata <= ram_q;
            state <= ST_DONE;
          end else if (line_valid && line_dirty) begin
            mem_cmd  <= 1'b1;
            mem_we   <= 1'b1;
            mem_addr <= {line_tag, req_idx, {OFS_W{1'b0}}};
            state    <= ST_WB_WAIT;
          end else begin
            mem_cmd  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= {req_tag, req_idx, {OFS_W{1'b0}}};
            state    <= ST_RF_WAIT;
          end
        end
        ST_WB_WAIT, ST_RF_WAIT: begin
          if (cnt == SETUP_LAST) begin
            cnt   <= '0;
            state <= (state == ST_WB_WAIT) ? ST_WB_DATA : ST_RF_DATA;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_WB_DATA: begin
          if (cnt == BEAT_LAST) begin
            cnt      <= '0;
            mem_cmd  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= {req_tag, req_idx, {OFS_W{1'b0}}};
            state    <= ST_RF_WAIT;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_RF_DATA: begin
          if (cnt == BEAT_LAST) begin
            cnt   <= '0;
            state <= ST_ISSUE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_ISSUE: state <= ST_CMP;
        ST_DONE: begin
          cpu_ready <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_cmd_single_R4: assert property (@(posedge clk) disable iff (rst)
    mem_cmd |=> !mem_cmd);

  assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  assert_hit_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CMP && hit) |=> (!mem_cmd && cpu_ready));

  assert_clean_miss_read_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CMP && !hit && !(line_valid && line_dirty)) |=> (mem_cmd && !mem_we));

  assert_victim_first_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CMP && !hit && line_valid && line_dirty) |=> (mem_cmd && mem_we));

  assert_wvalid_dir_R8: assert property (@(posedge clk) disable iff (rst)
    mem_wvalid |-> mem_we);

  assert_no_early_reply_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RF_DATA) |=> !cpu_ready);
endmodule

// File: tb/dm_cache_tb_top.sv
`timescale 1ns/1ps
module dm_cache_tb_top;
  localparam int SETUP     = 10;
  localparam int BEATS     = 16;
  localparam int LAT_HIT   = 2;
  localparam int LAT_CLEAN = SETUP + 20;
  localparam int LAT_DIRTY = 2 * SETUP + 36;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [1:0]  kind;     // 0 hit, 1 clean miss, 2 dirty miss
    logic        use_exp;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_1040, 32'h0, 2'd1, 1'b0, 32'h0},          // R2 empty row
    '{1'b0, 32'h0000_1044, 32'h0, 2'd0, 1'b0, 32'h0},          // R3
    '{1'b1, 32'h0000_1048, 32'hDEAD_0001, 2'd0, 1'b0, 32'h0},  // R7
    '{1'b0, 32'h0000_1048, 32'h0, 2'd0, 1'b1, 32'hDEAD_0001},  // R7
    '{1'b0, 32'h0000_2040, 32'h0, 2'd2, 1'b0, 32'h0},          // R8 R9
    '{1'b0, 32'h0000_1048, 32'h0, 2'd1, 1'b1, 32'hDEAD_0001},  // R8 write-back landed
    '{1'b0, 32'hA7D3_04BE, 32'h0, 2'd1, 1'b0, 32'h0},          // R1 R5 last word
    '{1'b1, 32'hA7D3_04BC, 32'h1234_5678, 2'd0, 1'b0, 32'h0},  // R7
    '{1'b1, 32'h0000_3080, 32'h0000_0055, 2'd1, 1'b0, 32'h0},  // R10
    '{1'b0, 32'h0000_3080, 32'h0, 2'd0, 1'b1, 32'h0000_0055},  // R10
    '{1'b0, 32'hA7D3_14BE, 32'h0, 2'd2, 1'b0, 32'h0},          // R9 same row 0x12
    '{1'b0, 32'hA7D3_04BC, 32'h0, 2'd1, 1'b1, 32'h1234_5678},  // R8
    '{1'b0, 32'h0000_0000, 32'h0, 2'd1, 1'b0, 32'h0}           // R5 word 0
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_cmd;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic        mem_wvalid;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  int cmd_count = 0;
  bit done = 1'b0;
  logic [31:0] mem_store [logic [31:0]];

  always #2 clk = ~clk;

  dm_cache #(.SETUP_CYCLES(SETUP)) dut_i (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_cmd(mem_cmd), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (mem_store.exists(a)) return mem_store[a];
    return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: fixed setup, then one word per cycle
  initial begin
    @(negedge clk);
    forever begin
      if (!rst && mem_cmd) begin
        logic [31:0] la;
        logic wr;
        la = mem_addr;
        wr = mem_we;
        cmd_count++;
        chk(la[5:0] == 6'd0, "R4 line-aligned burst address", la, {la[31:6], 6'd0});
        repeat (SETUP) @(negedge clk);
        for (int k = 0; k < BEATS; k++) begin
          if (wr) begin
            chk(mem_wvalid == 1'b1, "R8 write beat timing", 32'(mem_wvalid), 32'd1);
            mem_store[la + 32'(4 * k)] = mem_wdata;
          end else begin
            mem_rdata = mem_word(la + 32'(4 * k));
          end
          @(negedge clk);
        end
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output int lat, output int cmds, output logic [31:0] rd);
    int c0;
    c0 = cmd_count;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!cpu_ready && lat < 500);
    rd = cpu_rdata;
    cmds = cmd_count - c0;
    cpu_req = 1'b0;
    @(negedge clk);
    chk(cpu_ready == 1'b0, "R11 ready is a single-cycle pulse", 32'(cpu_ready), 32'd0);
  endtask

  function automatic int lat_of(input logic [1:0] k);
    return (k == 2'd0) ? LAT_HIT : (k == 2'd1) ? LAT_CLEAN : LAT_DIRTY;
  endfunction

  initial begin
    int lat, cmds;
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    chk(cpu_ready == 1'b0 && mem_cmd == 1'b0 && mem_wvalid == 1'b0,
        "R2 R11 outputs idle in reset", {29'd0, cpu_ready, mem_cmd, mem_wvalid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      access(v.we, v.addr, v.wdata, lat, cmds, rd);
      chk(lat == lat_of(v.kind), (v.kind == 0) ? "R3 R7 hit latency" :
          (v.kind == 1) ? "R4 R6 clean-miss latency" : "R8 dirty-miss latency",
          32'(lat), 32'(lat_of(v.kind)));
      chk(cmds == int'(v.kind), "R4 R7 R8 burst command count", 32'(cmds), 32'(v.kind));
      if (!v.we) begin
        logic [31:0] e;
        e = v.use_exp ? v.exp : mem_word({v.addr[31:2], 2'b00});
        chk(rd == e, "R1 R5 R6 read word", rd, e);
      end
    end

    // R9: alternating conflict pair on row 4 (both clean)
    for (int i = 0; i < 3; i++) begin
      logic [31:0] a;
      a = (i % 2 == 0) ? 32'h0000_5100 : 32'h0000_6100;
      access(1'b0, a, 32'h0, lat, cmds, rd);
      chk(lat == LAT_CLEAN, "R9 conflict evicts", 32'(lat), 32'(LAT_CLEAN));
      chk(rd == mem_word(a), "R9 conflict data", rd, mem_word(a));
    end

    // R10: write miss allocates, later evicted dirty
    access(1'b1, 32'h0000_7140, 32'h0000_CAFE, lat, cmds, rd);
    chk(lat == LAT_CLEAN, "R10 write-miss refill latency", 32'(lat), 32'(LAT_CLEAN));
    access(1'b0, 32'h0000_8140, 32'h0, lat, cmds, rd);
    chk(lat == LAT_DIRTY, "R10 allocated line is dirty", 32'(lat), 32'(LAT_DIRTY));
    chk(mem_word(32'h0000_7140) == 32'h0000_CAFE, "R10 written word reached memory",
        mem_word(32'h0000_7140), 32'h0000_CAFE);

    // R2: reset clears valid flags
    access(1'b0, 32'h0000_8140, 32'h0, lat, cmds, rd);
    chk(lat == LAT_HIT, "R2 line resident before reset", 32'(lat), 32'(LAT_HIT));
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    access(1'b0, 32'h0000_8140, 32'h0, lat, cmds, rd);
    chk(lat == LAT_CLEAN, "R2 miss after reset", 32'(lat), 32'(LAT_CLEAN));
    chk(rd == mem_word(32'h0000_8140), "R2 data after reset", rd, mem_word(32'h0000_8140));

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule